// File: doc/BRIEF.md
# Serial Addressed Wiper Latch Core

This block is the digital control core of a serially programmed bank of wiper positions. A host shifts 10-bit frames over a three-wire link made of a serial clock, an active-low select and a data line. The frame carries a 2-bit channel address followed by an 8-bit code. When the select line returns high, the address is decoded and the code is stored in exactly one channel latch. The analog side reads each channel's 8-bit code from `code_o`. It also reads two shutdown controls per channel: one opens the upper terminal and one ties the wiper to the lower terminal.

All serial pins are sampled on a single system clock. A serial clock rise is recognised as a 0-to-1 change between two samples. A select rise is found the same way. The bit that falls off the far end of the shift register is held in a latch and presented on an open-drain style output, so several devices can be daisy chained. An active-low preset returns every channel to midscale. An active-low shutdown parks the analog side but keeps the stored codes, and it keeps accepting writes so that new positions apply once shutdown is released.

The number of channels is a parameter: 1, 2 or 4. A frame whose address names a missing channel is dropped.

Top module: `wiper_latch_core`

## Requirements
- R1: A frame is received MSB first. Once 10 bits are in, the two oldest are the address (bit 9 = A1, bit 8 = A0) and the eight newest are the code (bit 7 down to bit 0, D7 arriving first).
- R2: While `ser_csn` is high, rises of `ser_clk` shift nothing. The register contents and `sdo_bit_o` stay as they were.
- R3: On each rise of `ser_csn`, the load uses the latest 10 bits in the register, whatever number of bits the frame had. A frame with fewer than 10 bits mixes in the newest older bits. With more than 10 bits, the oldest extra bits fall away.
- R4: A load changes only the addressed channel. Every other channel keeps its code.
- R5: Address value k (A1*2 + A0) selects channel k, whose code is `code_o[8k+7:8k]`.
- R6: While `rst_n` is low, every code is 0x80, the serial register is zero and the serial output latch is 0. Reset acts without waiting for a clock edge.
- R7: If reset and a select rise happen together, reset wins and every code reads 0x80.
- R8: While `shdn_n` is low, every bit of `a_open_o` and `w_short_o` is 1. Both return to 0 when `shdn_n` is high. Shutdown by itself never changes a code.
- R9: Frames completed during shutdown load their channel exactly as they do outside shutdown, and the code persists after release.
- R10: After each accepted shift, `sdo_bit_o` equals the bit that was entered ten shifts earlier. It is 0 while fewer than ten bits have been entered since reset.
- R11: `sdo_oe_o` is 1 only while `ser_csn` is low and `shdn_n` is high. `sdo_pull_low_o` is 1 exactly when `sdo_oe_o` is 1 and `sdo_bit_o` is 0, so the line is released high otherwise.
- R12: With NUM_CH below 4, a frame addressing channel NUM_CH or above changes no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low preset to midscale |
| ser_clk | input | 1 | Serial clock; bits shift on its rise |
| ser_csn | input | 1 | Active-low select; its rise loads a channel |
| ser_din | input | 1 | Serial data in |
| shdn_n | input | 1 | Active-low shutdown |
| code_o | output | NUM_CH*CODE_W | Stored codes, channel k at bits [8k+7:8k] |
| a_open_o | output | NUM_CH | Per-channel open control for the upper terminal |
| w_short_o | output | NUM_CH | Per-channel wiper-to-lower-terminal short control |
| sdo_oe_o | output | 1 | Serial output active |
| sdo_bit_o | output | 1 | Latched bit shifted out of the register |
| sdo_pull_low_o | output | 1 | Open-drain pull-down for the serial output |

## Verification
Every serial event takes effect one system clock after it is first seen. A `ser_clk` rise updates the register and `sdo_bit_o` at the first `clk` edge that samples the pin high. A `ser_csn` rise updates `code_o` at the first edge that samples select high. The shutdown controls, `sdo_oe_o` and `sdo_pull_low_o` are combinational from pins and the latch, and reset acts immediately. The bench changes inputs on the falling edge of `clk` and samples results on the following falling edge, so exactly one rising edge lies between stimulus and check. It sweeps every address against a spread of codes that includes 0x00 and 0xFF, on a 4-channel and a 2-channel instance.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Events found on the sampled serial pins in one system cycle.
  typedef struct packed {
    logic shift;
    logic load;
  } ser_evt_t;

  // Midscale code for a given code width.
  function automatic logic [31:0] midscale_of(int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

  // Whether a decoded address names a channel that exists.
  function automatic logic addr_in_range(logic [31:0] a, int unsigned n);
    return a < n;
  endfunction

  // Channel index carried by a frame address (A1*2 + A0).
  function automatic int unsigned chan_of(logic [1:0] a);
    return 2 * int'(a[1]) + int'(a[0]);
  endfunction

endpackage

// File: rtl/serial_front.sv
module serial_front #(
  parameter int unsigned FRAME_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_csn,
  input  logic                   ser_din,
  output logic [FRAME_W-1:0]     frame_o,
  output wiper_pkg::ser_evt_t    evt_o,
  output logic                   sdo_bit_o
);

  logic               sclk_q;
  logic               csn_q;
  logic [FRAME_W-1:0] shreg;
  logic               sdo_q;

  // Previous samples; reset high so a level already present is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= ser_clk;
      csn_q  <= ser_csn;
    end
  end

  assign evt_o.shift = ser_clk & ~sclk_q & ~ser_csn;
  assign evt_o.load  = ser_csn & ~csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sdo_q <= 1'b0;
    end else if (evt_o.shift) begin
      shreg <= {shreg[FRAME_W-2:0], ser_din};
      sdo_q <= shreg[FRAME_W-1];
    end
  end

  assign frame_o   = shreg;
  assign sdo_bit_o = sdo_q;

  // R2: a deselected interface leaves the register alone
  a_r2_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ser_csn |=> $stable(shreg));

  // R1: the newest bit lands in the LSB
  a_r1_newest_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.shift |=> (shreg[0] == $past(ser_din)));

  // R10: output latch takes the bit pushed off the far end
  a_r10_tap_far_end: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.shift |=> (sdo_q == $past(shreg[FRAME_W-1])));

  // R10: the tap only moves on a shift
  a_r10_tap_still: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_o.shift |=> $stable(sdo_q));

endmodule

// File: rtl/addr_decode.sv
module addr_decode #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] load_vec_o,
  output logic              drop_o
);

  logic addr_ok;

  assign addr_ok = wiper_pkg::addr_in_range(32'(addr_i), NUM_CH);
  assign drop_o  = load_i & ~addr_ok;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign load_vec_o[c] = load_i && (addr_i == ADDR_W'(c));
  end

  // R4: never more than one latch strobed
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec_o));

  // R12: a dropped frame strobes nothing
  a_r12_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> (load_vec_o == '0));

  // R5: an in-range load strobes exactly one latch
  a_r5_hit_one: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !drop_o) |-> ($countones(load_vec_o) == 1));

endmodule

// File: rtl/chan_latch.sv
module chan_latch #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] code_in,
  input  logic              shdn_n,
  output logic [CODE_W-1:0] code_o,
  output logic              a_open_o,
  output logic              w_short_o
);

  localparam logic [CODE_W-1:0] MID = CODE_W'(wiper_pkg::midscale_of(CODE_W));

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= MID;
    else if (load_en) code_q <= code_in;
  end

  assign code_o    = code_q;
  assign a_open_o  = ~shdn_n;
  assign w_short_o = ~shdn_n;

  // R4: an unselected latch holds
  a_r4_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(code_q));

  // R9: a strobe loads whether or not shutdown is active
  a_r9_load_any_mode: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (code_q == $past(code_in)));

  // R6: leaving reset the code is midscale
  a_r6_preset_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code_q == MID));

endmodule

// File: rtl/wiper_latch_core.sv
module wiper_latch_core #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_csn,
  input  logic                     ser_din,
  input  logic                     shdn_n,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        a_open_o,
  output logic [NUM_CH-1:0]        w_short_o,
  output logic                     sdo_oe_o,
  output logic                     sdo_bit_o,
  output logic                     sdo_pull_low_o
);

  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned FRAME_W = ADDR_W + CODE_W;

  logic [FRAME_W-1:0]  frame;
  wiper_pkg::ser_evt_t evt;
  logic [NUM_CH-1:0]   load_vec;
  logic                drop;
  logic [ADDR_W-1:0]   frame_addr;
  logic [CODE_W-1:0]   frame_code;

  serial_front #(.FRAME_W(FRAME_W)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .ser_csn   (ser_csn),
    .ser_din   (ser_din),
    .frame_o   (frame),
    .evt_o     (evt),
    .sdo_bit_o (sdo_bit_o)
  );

  assign frame_addr = frame[FRAME_W-1 -: ADDR_W];
  assign frame_code = frame[CODE_W-1:0];

  addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (evt.load),
    .addr_i     (frame_addr),
    .load_vec_o (load_vec),
    .drop_o     (drop)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_latch #(.CODE_W(CODE_W)) u_lat (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_vec[c]),
      .code_in   (frame_code),
      .shdn_n    (shdn_n),
      .code_o    (code_o[c*CODE_W +: CODE_W]),
      .a_open_o  (a_open_o[c]),
      .w_short_o (w_short_o[c])
    );
  end

  assign sdo_oe_o       = ~ser_csn & shdn_n;
  assign sdo_pull_low_o = sdo_oe_o & ~sdo_bit_o;

  // R12: a dropped frame leaves every code as it was
  a_r12_drop_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(code_o));

  // R11: the output never pulls low in shutdown
  a_r11_quiet_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> !sdo_pull_low_o);

  // R11: the output never pulls low while deselected
  a_r11_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ser_csn |-> !sdo_pull_low_o);

endmodule

// File: tb/wiper_latch_core_tb.sv
module wiper_latch_core_tb;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_csn = 1'b1;
  logic ser_din = 1'b0;
  logic shdn_n = 1'b1;

  logic [31:0] code4;
  logic [3:0]  aop4, wsh4;
  logic        oe4, bit4, pl4;
  logic [15:0] code2;
  logic [1:0]  aop2, wsh2;
  logic        oe2, bit2, pl2;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [9:0] m_sr;
  logic       m_sdo;
  logic [7:0] m_code [4];

  always #(CLK_P/2) clk = ~clk;

  wiper_latch_core #(.NUM_CH(4), .CODE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_csn(ser_csn),
    .ser_din(ser_din), .shdn_n(shdn_n), .code_o(code4), .a_open_o(aop4),
    .w_short_o(wsh4), .sdo_oe_o(oe4), .sdo_bit_o(bit4), .sdo_pull_low_o(pl4)
  );

  wiper_latch_core #(.NUM_CH(2), .CODE_W(8)) u_dut_n2 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_csn(ser_csn),
    .ser_din(ser_din), .shdn_n(shdn_n), .code_o(code2), .a_open_o(aop2),
    .w_short_o(wsh2), .sdo_oe_o(oe2), .sdo_bit_o(bit2), .sdo_pull_low_o(pl2)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sr = '0;
    m_sdo = 1'b0;
    for (int i = 0; i < 4; i++) m_code[i] = 8'h80;
  endtask

  // req_hit for the addressed channel, R4 for the rest, R12 for the small instance
  task automatic check_codes(string req_hit, int hit);
    for (int i = 0; i < 4; i++)
      chk((i == hit) ? req_hit : "R4", $sformatf("ch%0d", i),
          int'(code4[8*i +: 8]), int'(m_code[i]));
    for (int i = 0; i < 2; i++)
      chk("R12", $sformatf("n2 ch%0d", i), int'(code2[8*i +: 8]), int'(m_code[i]));
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); ser_clk = 1'b0; ser_din = b;
    @(negedge clk); ser_clk = 1'b1;
    m_sdo = m_sr[9];
    m_sr = {m_sr[8:0], b};
    @(negedge clk);
    chk("R10", "sdo bit", int'(bit4), int'(m_sdo));
    chk("R11", "sdo oe", int'(oe4), int'(shdn_n));
    chk("R11", "pull low", int'(pl4), int'(shdn_n & ~m_sdo));
  endtask

  task automatic cs_low();
    @(negedge clk); ser_csn = 1'b0;
  endtask

  // returns the addressed channel of the load
  task automatic cs_high(output int hit);
    @(negedge clk); ser_csn = 1'b1;
    hit = 2 * int'(m_sr[9]) + int'(m_sr[8]);
    m_code[hit] = m_sr[7:0];
    @(negedge clk);
  endtask

  task automatic frame(int a, int code, string req);
    int hit;
    logic [9:0] w;
    w = {2'(a), 8'(code)};
    cs_low();
    for (int i = 9; i >= 0; i--) send_bit(w[i]);
    cs_high(hit);
    check_codes(req, hit);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    if (!done) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hit;
    logic [12:0] longw;
    model_reset();
    repeat (3) @(negedge clk);
    // R6: preset state
    check_codes("R6", 0);
    chk("R6", "sdo bit", int'(bit4), 0);
    chk("R11", "oe deselected", int'(oe4), 0);
    chk("R8", "a_open idle", int'(aop4), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R5: every address against a spread of codes
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 8; k++) begin
        int code;
        code = (k == 0) ? 0 : (k == 7) ? 255 : ((a * 61 + k * 37 + 5) & 255);
        frame(a, code, k[0] ? "R5" : "R1");
      end
    end

    // R2: serial clocks while deselected are ignored
    frame(0, 8'h00, "R1");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ser_clk = 1'b0; ser_din = 1'b1;
      @(negedge clk); ser_clk = 1'b1;
    end
    @(negedge clk);
    chk("R2", "sdo bit after idle clocks", int'(bit4), int'(m_sdo));
    cs_low();
    cs_high(hit);
    check_codes("R2", hit);

    // R3: short frame uses latest ten bits
    frame(2, 8'h5A, "R5");
    cs_low();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    cs_high(hit);
    check_codes("R3", hit);
    chk("R3", "short frame target", hit, 1);

    // R3: long frame keeps only the newest ten bits
    longw = 13'b101_1101100011;
    cs_low();
    for (int i = 12; i >= 0; i--) send_bit(longw[i]);
    cs_high(hit);
    check_codes("R3", hit);
    chk("R3", "long frame code", int'(code4[8*3 +: 8]), 8'h63);

    // R8 / R9: shutdown keeps codes, still accepts writes
    @(negedge clk); shdn_n = 1'b0;
    @(negedge clk);
    chk("R8", "a_open", int'(aop4), 4'hF);
    chk("R8", "w_short", int'(wsh4), 4'hF);
    chk("R8", "n2 a_open", int'(aop2), 2'h3);
    check_codes("R8", 3);
    frame(1, 8'hC3, "R9");
    frame(3, 8'h0F, "R9");
    @(negedge clk); shdn_n = 1'b1;
    @(negedge clk);
    chk("R8", "a_open released", int'(aop4), 0);
    chk("R8", "w_short released", int'(wsh4), 0);
    check_codes("R9", 1);

    // R12: out-of-range addresses on the small instance
    frame(2, 8'h11, "R12");
    frame(3, 8'hEE, "R12");

    // R7: reset coincides with select rise
    frame(0, 8'hFF, "R1");
    cs_low();
    begin
      logic [9:0] w;
      w = {2'd1, 8'h3C};
      for (int i = 9; i >= 0; i--) send_bit(w[i]);
    end
    @(negedge clk); ser_csn = 1'b1; rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_codes("R7", 1);
    chk("R6", "sdo cleared", int'(bit4), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_codes("R6", 0);
    cs_low();
    @(negedge clk);
    chk("R6", "pull low after reset", int'(pl4), 1);
    chk("R11", "oe selected", int'(oe4), 1);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    send_bit(1'b0);
    chk("R10", "tap after ten ones", int'(bit4), 1);
    cs_high(hit);
    check_codes("R1", hit);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule